// File: doc/BRIEF.md
# Bipolar Receive Line Decoder (HDB3 / B3ZS / AMI)

This block sits behind a receive slicer and turns a bipolar line signal, delivered as two single-bit rails (one for positive pulses, one for negative pulses) on a recovered receive clock, into a single-rail NRZ bit stream. In HDB3 and B3ZS modes it recognises the zero-substitution groups that the far-end encoder inserted and turns them back into the zeros they replaced. A two-bit mode input can instead select plain AMI decoding, where every pulse becomes a one.

Decoded bits leave through a fixed four-stage delay in every mode. The delay lets a pulse already accepted as data be cancelled when a later bipolar violation shows that it was the balancing pulse of a substitution group. Alongside the data, a one-cycle code-violation strobe reports violations that fit no substitution group, zero runs that a correct encoder never sends, and symbols with both rails high.

Top module: `bipolar_rx_decoder`

## Requirements
- R1: A symbol is a mark when pos_i or neg_i is high. mode_i selects the line code: 2'b00 HDB3, 2'b01 B3ZS, 2'b10 and 2'b11 AMI. The decoded bit for the symbol sampled at rising edge n is on data_o during the cycle that follows edge n+3, in every mode.
- R2: In AMI mode every mark decodes to 1 and every zero symbol to 0; no pulse is ever removed.
- R3: In HDB3 mode a violation pulse (a single-rail mark with the same polarity as the previous single-rail mark) preceded by at least two zero symbols is valid; the group 0 0 0 V decodes to four zeros with no code violation.
- R4: In HDB3 mode, for the group B 0 0 V with a valid V, the B pulse three symbols before V is also decoded as 0, so the group yields four zeros.
- R5: In B3ZS mode a violation pulse preceded by at least one zero symbol is valid; the groups 0 0 V and B 0 V each decode to three zeros with no code violation.
- R6: A violation pulse that is not valid in the current mode (any violation in AMI mode) decodes as 1 and raises cv_o for one cycle, the cycle following the edge that sampled it.
- R7: cv_o is raised for the 4th and every further consecutive zero symbol in HDB3 mode and for the 3rd and further in B3ZS mode; AMI mode never flags zero runs, and zero symbols received after reset before the first mark are not counted.
- R8: A symbol with both rails high raises cv_o, decodes as 1, and leaves the stored polarity unchanged, so the next single-rail mark is judged against the mark before it.
- R9: The first single-rail mark after reset is never treated as a violation.
- R10: rst is synchronous and active high; it clears the delay pipeline, the zero-run count and the polarity state, and holds data_o and cv_o at 0 in the cycle after each edge where it is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; rails sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pos_i | input | 1 | Positive-pulse rail |
| neg_i | input | 1 | Negative-pulse rail |
| mode_i | input | 2 | Line code select: 00 HDB3, 01 B3ZS, 1x AMI |
| data_o | output | 1 | Decoded NRZ data, four-cycle latency |
| cv_o | output | 1 | One-cycle code-violation strobe |

## Verification
The bound checker watches, on every cycle, that no one appears on data_o unless a mark arrived four edges earlier, that a both-rails symbol is always followed by a violation strobe, that alternating adjacent marks never produce one, and that zero symbols in AMI mode are never flagged. Whether a substitution group is recognised and its balancing pulse cancelled, where the zero-run threshold falls in each mode, and how the polarity state behaves across reset and after a both-rails symbol depend on multi-symbol histories, so only the bench's scripted line sequences show them.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

    localparam int PIPE_DEPTH = 4;   // stages between rail sample and data_o
    localparam int ZCNT_W     = 3;   // zero-run counter width (saturating)

    typedef enum logic [1:0] {
        MODE_HDB3    = 2'b00,
        MODE_B3ZS    = 2'b01,
        MODE_AMI     = 2'b10,
        MODE_AMI_ALT = 2'b11
    } line_mode_e;

    typedef struct packed {
        logic mark;   // pulse on either rail
        logic both;   // both rails high together
        logic bpv;    // single-rail pulse repeating the last polarity
    } sym_t;

    function automatic logic subst_mode(line_mode_e m);
        return (m == MODE_HDB3) || (m == MODE_B3ZS);
    endfunction

    // zero symbols that must precede a violation for it to close a group
    function automatic int lead_zeros_needed(line_mode_e m);
        case (m)
            MODE_HDB3: return 2;
            MODE_B3ZS: return 1;
            default:   return 0;
        endcase
    endfunction

    // zero-run length that first counts as a violation; 0 disables
    function automatic int zero_run_limit(line_mode_e m);
        case (m)
            MODE_HDB3: return 4;
            MODE_B3ZS: return 3;
            default:   return 0;
        endcase
    endfunction

    // stages cleared when a valid violation enters: bit 0 drops V itself,
    // the upper bit drops the balancing pulse as it moves down the line
    function automatic logic [PIPE_DEPTH-1:0] subst_kill_mask(line_mode_e m);
        logic [PIPE_DEPTH-1:0] k;
        k = '0;
        if (subst_mode(m)) begin
            k[0] = 1'b1;
            k[lead_zeros_needed(m) + 1] = 1'b1;
        end
        return k;
    endfunction

endpackage

// File: rtl/bpd_classify.sv
module bpd_classify
    import bpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pos_i,
    input  logic neg_i,
    output sym_t sym_o
);

    logic last_pos_q;   // 1: last single-rail mark was positive
    logic seen_q;       // a single-rail mark has arrived since reset

    always_comb begin
        sym_o.mark = pos_i | neg_i;
        sym_o.both = pos_i & neg_i;
        sym_o.bpv  = (pos_i ^ neg_i) & seen_q & (pos_i == last_pos_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pos_q <= 1'b0;
            seen_q     <= 1'b0;
        end else if (pos_i ^ neg_i) begin
            last_pos_q <= pos_i;
            seen_q     <= 1'b1;
        end
    end

endmodule

// File: rtl/bpd_zero_run.sv
module bpd_zero_run
    import bpd_pkg::*;
#(
    parameter int W = ZCNT_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mark_i,
    input  line_mode_e mode_i,
    output logic [W-1:0] lead_o,    // zeros immediately before this symbol
    output logic       excess_o     // this zero makes the run too long
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;
    logic         armed_q;
    int           limit;

    assign cnt_inc = (cnt_q == {W{1'b1}}) ? cnt_q : cnt_q + 1'b1;
    assign limit   = zero_run_limit(mode_i);
    assign lead_o  = cnt_q;
    assign excess_o = ~mark_i & armed_q & (limit != 0) & (int'(cnt_inc) >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (mark_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (armed_q) begin
            cnt_q   <= cnt_inc;
        end
    end

endmodule

// File: rtl/bpd_pipe.sv
module bpd_pipe #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_i,
    input  logic [DEPTH-1:0] kill_i,   // kill_i[k] clears the bit entering stage k
    output logic             bit_o
);

    logic [DEPTH-1:0] stage_q;

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_stage
            logic feed;
            if (k == 0) begin : g_head
                assign feed = bit_i;
            end else begin : g_body
                assign feed = stage_q[k-1];
            end
            always_ff @(posedge clk) begin
                if (rst) stage_q[k] <= 1'b0;
                else     stage_q[k] <= feed & ~kill_i[k];
            end
        end
    endgenerate

    assign bit_o = stage_q[DEPTH-1];

endmodule

// File: rtl/bipolar_rx_decoder.sv
module bipolar_rx_decoder
    import bpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pos_i,
    input  logic       neg_i,
    input  logic [1:0] mode_i,
    output logic       data_o,
    output logic       cv_o
);

    line_mode_e            mode;
    sym_t                  sym;
    logic [ZCNT_W-1:0]     lead;
    logic                  excess;
    logic                  subst_ok;
    logic [PIPE_DEPTH-1:0] kill;
    logic                  cv_q;

    assign mode = line_mode_e'(mode_i);

    bpd_classify u_cls (
        .clk   (clk),
        .rst   (rst),
        .pos_i (pos_i),
        .neg_i (neg_i),
        .sym_o (sym)
    );

    bpd_zero_run #(.W(ZCNT_W)) u_zrun (
        .clk      (clk),
        .rst      (rst),
        .mark_i   (sym.mark),
        .mode_i   (mode),
        .lead_o   (lead),
        .excess_o (excess)
    );

    // a violation closes a substitution group only after enough zeros
    assign subst_ok = sym.bpv & subst_mode(mode) & (int'(lead) >= lead_zeros_needed(mode));
    assign kill     = subst_ok ? subst_kill_mask(mode) : '0;

    bpd_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (sym.mark),
        .kill_i (kill),
        .bit_o  (data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) cv_q <= 1'b0;
        else     cv_q <= (sym.bpv & ~subst_ok) | excess | sym.both;
    end

    assign cv_o = cv_q;

endmodule

// File: rtl/bpd_checker.sv
module bpd_checker (
    input logic       clk,
    input logic       rst,
    input logic       pos_i,
    input logic       neg_i,
    input logic [1:0] mode_i,
    input logic       data_o,
    input logic       cv_o
);

    // a one on the output needs a mark four edges back (R1)
    assert_data_needs_mark_R1: assert property (@(posedge clk) disable iff (rst)
        data_o |-> $past(pos_i || neg_i, 4));

    // both rails high is always reported (R8)
    assert_both_rails_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (pos_i && neg_i) |=> cv_o);

    // zero symbols in AMI mode are never flagged (R7)
    assert_ami_zero_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_i[1] && !pos_i && !neg_i) |=> !cv_o);

    // adjacent marks of opposite polarity are never violations (R6)
    assert_alternating_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        ((pos_i ^ neg_i) && $past(pos_i ^ neg_i) && (pos_i != $past(pos_i))) |=> !cv_o);

endmodule

bind bipolar_rx_decoder bpd_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .pos_i  (pos_i),
    .neg_i  (neg_i),
    .mode_i (mode_i),
    .data_o (data_o),
    .cv_o   (cv_o)
);

// File: tb/tb_bipolar_rx_decoder.sv
module tb_bipolar_rx_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pos_i = 1'b0;
    logic       neg_i = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic       data_o;
    logic       cv_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    bipolar_rx_decoder dut (
        .clk    (clk),
        .rst    (rst),
        .pos_i  (pos_i),
        .neg_i  (neg_i),
        .mode_i (mode_i),
        .data_o (data_o),
        .cv_o   (cv_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    // vector: {req[3:0], rs, mode[1:0], pos, neg, exp_data, exp_cv}
    // exp_data belongs to this symbol and is checked three edges later
    localparam int NV = 64;
    localparam logic [10:0] VEC [NV] = '{
        // HDB3 segment
        {4'd10, 7'b1_00_00_0_0},   // R10 reset
        {4'd9,  7'b0_00_10_1_0},   // R9 first mark
        {4'd1,  7'b0_00_01_1_0},   // R1
        {4'd1,  7'b0_00_10_1_0},   // R1
        {4'd3,  7'b0_00_00_0_0},   // R3 0
        {4'd3,  7'b0_00_00_0_0},   // R3 0
        {4'd3,  7'b0_00_00_0_0},   // R3 0
        {4'd3,  7'b0_00_10_0_0},   // R3 V (+)
        {4'd4,  7'b0_00_01_0_0},   // R4 B (-)
        {4'd4,  7'b0_00_00_0_0},   // R4 0
        {4'd4,  7'b0_00_00_0_0},   // R4 0
        {4'd4,  7'b0_00_01_0_0},   // R4 V (-)
        {4'd1,  7'b0_00_10_1_0},   // R1
        {4'd1,  7'b0_00_01_1_0},   // R1
        {4'd6,  7'b0_00_01_1_1},   // R6 V with no zeros before
        {4'd7,  7'b0_00_00_0_0},   // R7
        {4'd7,  7'b0_00_00_0_0},   // R7
        {4'd7,  7'b0_00_00_0_0},   // R7
        {4'd7,  7'b0_00_00_0_1},   // R7 fourth zero
        {4'd7,  7'b0_00_00_0_1},   // R7 fifth zero
        {4'd1,  7'b0_00_10_1_0},   // R1
        {4'd1,  7'b0_00_00_0_0},   // R1 flush
        {4'd1,  7'b0_00_00_0_0},
        {4'd1,  7'b0_00_00_0_0},
        // B3ZS segment
        {4'd10, 7'b1_01_00_0_0},   // R10 reset
        {4'd9,  7'b0_01_10_1_0},   // R9
        {4'd1,  7'b0_01_01_1_0},   // R1
        {4'd5,  7'b0_01_00_0_0},   // R5 0
        {4'd5,  7'b0_01_00_0_0},   // R5 0
        {4'd5,  7'b0_01_01_0_0},   // R5 V (-)
        {4'd5,  7'b0_01_10_0_0},   // R5 B (+)
        {4'd5,  7'b0_01_00_0_0},   // R5 0
        {4'd5,  7'b0_01_10_0_0},   // R5 V (+)
        {4'd7,  7'b0_01_00_0_0},   // R7
        {4'd7,  7'b0_01_00_0_0},   // R7
        {4'd7,  7'b0_01_00_0_1},   // R7 third zero
        {4'd1,  7'b0_01_01_1_0},   // R1
        {4'd1,  7'b0_01_10_1_0},   // R1
        {4'd6,  7'b0_01_10_1_1},   // R6 V with no zero before
        {4'd7,  7'b0_01_00_0_0},   // R7
        {4'd7,  7'b0_01_00_0_0},   // R7
        {4'd7,  7'b0_01_00_0_1},   // R7
        // AMI segment
        {4'd10, 7'b1_10_00_0_0},   // R10 reset
        {4'd2,  7'b0_10_10_1_0},   // R2
        {4'd2,  7'b0_10_00_0_0},   // R2
        {4'd2,  7'b0_10_00_0_0},   // R2
        {4'd2,  7'b0_10_00_0_0},   // R2
        {4'd6,  7'b0_10_10_1_1},   // R6 any violation in AMI
        {4'd2,  7'b0_10_01_1_0},   // R2
        {4'd7,  7'b0_10_00_0_0},   // R7 no zero-run flag in AMI
        {4'd7,  7'b0_10_00_0_0},
        {4'd7,  7'b0_10_00_0_0},
        // HDB3 again: idle zeros, both rails
        {4'd10, 7'b1_00_00_0_0},   // R10 reset
        {4'd7,  7'b0_00_00_0_0},   // R7 zeros before first mark
        {4'd7,  7'b0_00_00_0_0},
        {4'd7,  7'b0_00_00_0_0},
        {4'd7,  7'b0_00_00_0_0},
        {4'd9,  7'b0_00_10_1_0},   // R9
        {4'd8,  7'b0_00_11_1_1},   // R8 both rails
        {4'd8,  7'b0_00_10_1_1},   // R8 polarity kept: repeat is a violation
        {4'd1,  7'b0_00_01_1_0},   // R1
        {4'd1,  7'b0_00_00_0_0},
        {4'd1,  7'b0_00_00_0_0},
        {4'd1,  7'b0_00_00_0_0}
    };

    logic       expq [4];
    logic [3:0] reqq [4];

    task automatic check(string what, int req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic apply(logic r, logic [1:0] m, logic p, logic n);
        @(negedge clk);
        rst    = r;
        mode_i = m;
        pos_i  = p;
        neg_i  = n;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        check("data_o in reset", 10, data_o, 1'b0);   // R10
        check("cv_o in reset",   10, cv_o,   1'b0);   // R10

        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            v = VEC[i];
            apply(v[6], v[5:4], v[3], v[2]);
            if (v[6]) begin
                for (int k = 0; k < 4; k++) begin
                    expq[k] = 1'b0;
                    reqq[k] = 4'd10;
                end
                check("data_o after reset", 10, data_o, 1'b0);
                check("cv_o after reset",   10, cv_o,   1'b0);
            end else begin
                for (int k = 3; k > 0; k--) begin
                    expq[k] = expq[k-1];
                    reqq[k] = reqq[k-1];
                end
                expq[0] = v[1];
                reqq[0] = v[10:7];
                check($sformatf("data_o vec %0d", i), int'(reqq[3]), data_o, expq[3]);
                check($sformatf("cv_o vec %0d", i),   int'(v[10:7]), cv_o,   v[0]);
            end
        end

        // directed: reset mid-stream clears pipeline and polarity (R10, R9)
        apply(1'b0, 2'b00, 1'b0, 1'b1);
        apply(1'b0, 2'b00, 1'b1, 1'b0);
        apply(1'b1, 2'b00, 1'b1, 1'b0);
        check("data_o reset mid-stream", 10, data_o, 1'b0);   // R10
        check("cv_o reset mid-stream",   10, cv_o,   1'b0);
        apply(1'b1, 2'b00, 1'b1, 1'b0);
        check("data_o reset held",       10, data_o, 1'b0);
        apply(1'b0, 2'b00, 1'b1, 1'b0);
        check("cv_o first mark same polarity as pre-reset", 9, cv_o, 1'b0);   // R9
        check("data_o pipeline cleared", 10, data_o, 1'b0);
        apply(1'b0, 2'b00, 1'b0, 1'b0);
        check("data_o latency edge+1", 1, data_o, 1'b0);   // R1
        apply(1'b0, 2'b00, 1'b0, 1'b0);
        check("data_o latency edge+2", 1, data_o, 1'b0);
        apply(1'b0, 2'b00, 1'b0, 1'b0);
        check("data_o latency edge+3", 1, data_o, 1'b1);
        apply(1'b0, 2'b00, 1'b0, 1'b0);
        check("data_o latency edge+4", 1, data_o, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule